// File: doc/BRIEF.md
# Multi-Agent Steering Semaphore

This block guards one shared steering selector that several agents use, for example a host driver and on-chip firmware. Each agent has its own register port into the block. It does not request a grant and then wait for a reply. A read of the register is itself the attempt to acquire it. If the read returns 1, the agent now owns the selector. If the read returns 0, the agent must try again. The owner frees the semaphore by writing a value with bit 0 set. Each agent keeps its own polling limit in software, so the block has no timer.

An agent's read returns its result in the same cycle. When the semaphore is free, the winning read takes ownership at the next clock edge. If several agents read in the same cycle while the semaphore is free, a fixed priority decides: the agent with the lowest index wins. While the semaphore is held, every read returns 0, including a read by the owner. Writes from agents that do not own the semaphore are ignored. Writes that leave bit 0 clear are also ignored.

Top module: `steer_sem`

## Requirements
- R1: After reset the semaphore is free with no owner, so the first read by any agent returns 1.
- R2: A read by a single agent while the semaphore is free returns 1 in that cycle, and that agent owns the semaphore from the next clock edge.
- R3: Any read while the semaphore is held returns 0. This includes a read by the owner and a read made in the same cycle as the owner's release write.
- R4: When several agents read in the same cycle while the semaphore is free, the agent with the lowest index reads 1 and every other agent reads 0.
- R5: A write by the owner with bit 0 of its data equal to 1 frees the semaphore from the next clock edge. The other data bits are not examined.
- R6: A write by an agent that is not the owner leaves the semaphore held by the same owner.
- R7: A write by the owner with bit 0 of its data equal to 0 leaves the semaphore held.
- R8: Bits 1 and above of every agent's read data are always 0. The result is carried in bit 0 only.
- R9: Writes while the semaphore is free have no effect, so a later read still acquires it.
- R10: At most one agent reads 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | NUM_AGENTS | One read strobe per agent; a read is an acquire attempt |
| wr_en_i | input | NUM_AGENTS | One write strobe per agent; a write is a release attempt |
| wr_data_i | input | NUM_AGENTS*DATA_W | Write data, agent a in bits [a*DATA_W +: DATA_W] |
| rd_data_o | output | NUM_AGENTS*DATA_W | Read data, available in the same cycle, agent a in bits [a*DATA_W +: DATA_W] |

## Verification
The assertions check the following on every cycle:
- at most one agent reads 1;
- a 1 goes only to an agent that is reading, and never while the semaphore is held or while a lower-index agent is also reading;
- the upper read bits stay zero;
- a grant leads to the held state;
- a held semaphore keeps the same owner until a valid release, and a valid release frees it.

Some behaviour is visible only from the bench's scenarios, because it depends on the order of accesses. These scenarios show that:
- a release attempt by a non-owner, or a write with bit 0 clear, is really ignored;
- a read in the same cycle as a release returns 0, and the read after it wins;
- writes made while the semaphore is free leave it free to acquire.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic {
    SEM_FREE = 1'b0,
    SEM_HELD = 1'b1
  } sem_state_e;
endpackage

// File: rtl/sem_prio_pick.sv
module sem_prio_pick #(
  parameter int NUM_AGENTS = 3,
  parameter int IDX_W      = 2
) (
  input  logic [NUM_AGENTS-1:0] req_i,
  output logic [NUM_AGENTS-1:0] grant_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic                  any_o
);
  // Scan from the top index down so that the lowest requester is assigned last and wins.
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = NUM_AGENTS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/sem_release_dec.sv
module sem_release_dec #(
  parameter int NUM_AGENTS = 3,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 2
) (
  input  logic [NUM_AGENTS-1:0]        wr_en_i,
  input  logic [NUM_AGENTS*DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]             owner_i,
  input  logic                         held_i,
  output logic                         release_o
);
  logic sel_en, sel_bit;

  // Only the owner's strobe and bit 0 of the owner's data are examined.
  always_comb begin
    sel_en  = 1'b0;
    sel_bit = 1'b0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (owner_i == IDX_W'(i)) begin
        sel_en  = wr_en_i[i];
        sel_bit = wr_data_i[i*DATA_W];
      end
    end
  end

  assign release_o = held_i & sel_en & sel_bit;

  // The other data bits do not affect the result.
  logic unused_data;
  assign unused_data = ^wr_data_i;
endmodule

// File: rtl/sem_owner_reg.sv
module sem_owner_reg #(
  parameter int IDX_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  acquire_i,
  input  logic [IDX_W-1:0]      acq_idx_i,
  input  logic                  release_i,
  output sem_pkg::sem_state_e   state_o,
  output logic [IDX_W-1:0]      owner_o
);
  import sem_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= SEM_FREE;
      owner_o <= '0;
    end else if (release_i) begin
      state_o <= SEM_FREE;
      owner_o <= '0;
    end else if (acquire_i && state_o == SEM_FREE) begin
      state_o <= SEM_HELD;
      owner_o <= acq_idx_i;
    end
  end

  assert_release_frees_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> state_o == SEM_FREE);
  assert_owner_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == SEM_HELD && !release_i) |=> (state_o == SEM_HELD && $stable(owner_o)));
  assert_free_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == SEM_FREE && !acquire_i) |=> state_o == SEM_FREE);
endmodule

// File: rtl/steer_sem.sv
module steer_sem #(
  parameter int NUM_AGENTS = 3,
  parameter int DATA_W     = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_AGENTS-1:0]        rd_en_i,
  input  logic [NUM_AGENTS-1:0]        wr_en_i,
  input  logic [NUM_AGENTS*DATA_W-1:0] wr_data_i,
  output logic [NUM_AGENTS*DATA_W-1:0] rd_data_o
);
  import sem_pkg::*;

  localparam int IDX_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1;

  sem_state_e              state_q;
  logic [IDX_W-1:0]        owner_q;
  logic [NUM_AGENTS-1:0]   req, grant, rd_bit;
  logic [IDX_W-1:0]        grant_idx;
  logic                    grant_any, release_w;

  // Reads compete only while the semaphore is free.
  assign req = rd_en_i & {NUM_AGENTS{state_q == SEM_FREE}};

  sem_prio_pick #(.NUM_AGENTS(NUM_AGENTS), .IDX_W(IDX_W)) u_pick (
    .req_i   (req),
    .grant_o (grant),
    .idx_o   (grant_idx),
    .any_o   (grant_any)
  );

  sem_release_dec #(.NUM_AGENTS(NUM_AGENTS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rel (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .owner_i   (owner_q),
    .held_i    (state_q == SEM_HELD),
    .release_o (release_w)
  );

  sem_owner_reg #(.IDX_W(IDX_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acquire_i (grant_any),
    .acq_idx_i (grant_idx),
    .release_i (release_w),
    .state_o   (state_q),
    .owner_o   (owner_q)
  );

  for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_port
    assign rd_data_o[a*DATA_W +: DATA_W] = {{(DATA_W-1){1'b0}}, grant[a]};
    assign rd_bit[a] = rd_data_o[a*DATA_W];

    assert_grant_needs_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_bit[a] |-> rd_en_i[a]);
    assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[a*DATA_W+1 +: DATA_W-1] == '0);
    if (a > 0) begin : g_prio
      assert_lowest_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_bit[a] |-> (rd_en_i[a-1:0] == '0));
    end
  end

  assert_single_winner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_bit));
  assert_held_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SEM_HELD |-> rd_bit == '0);
  assert_grant_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_bit) |=> state_q == SEM_HELD);
  assert_free_read_wins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEM_FREE && |rd_en_i) |-> (|rd_bit));
endmodule

// File: tb/steer_sem_tb.sv
module steer_sem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int DW = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N-1:0]      rd_en_i = '0;
  logic [N-1:0]      wr_en_i = '0;
  logic [N*DW-1:0]   wr_data_i = '0;
  logic [N*DW-1:0]   rd_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state.
  bit ref_held  = 1'b0;
  int ref_owner = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  steer_sem #(.NUM_AGENTS(N), .DATA_W(DW)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o)
  );

  // Drive one cycle of accesses, compare against the model, then advance the model at the edge.
  task automatic step(input logic [N-1:0] rd, input logic [N-1:0] wr,
                      input logic [N*DW-1:0] wd, input string tag);
    int win;
    int ones;
    logic [DW-1:0] exp_v;
    logic [DW-1:0] act_v;
    @(negedge clk_i);
    rd_en_i   = rd;
    wr_en_i   = wr;
    wr_data_i = wd;
    #1;
    win = -1;
    if (!ref_held)
      for (int i = N - 1; i >= 0; i--) if (rd[i]) win = i;
    ones = 0;
    for (int i = 0; i < N; i++) begin
      exp_v = (win == i) ? 32'd1 : 32'd0;
      act_v = rd_data_o[i*DW +: DW];
      checks++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s/R8 agent %0d: actual %h expected %h", tag, i, act_v, exp_v);
      end
      if (act_v[0] === 1'b1) ones++;
    end
    checks++;
    if (ones > 1) begin
      fails++;
      $display("FAIL R10: actual %0d winners expected at most 1", ones);
    end
    @(posedge clk_i);
    if (ref_held && wr[ref_owner] && wd[ref_owner*DW]) begin
      ref_held  = 1'b0;
      ref_owner = 0;
    end else if (!ref_held && win >= 0) begin
      ref_held  = 1'b1;
      ref_owner = win;
    end
  endtask

  function automatic logic [N*DW-1:0] wdat(input int agent, input logic [DW-1:0] v);
    logic [N*DW-1:0] r;
    r = '0;
    r[agent*DW +: DW] = v;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(3'b010, 3'b000, '0, "R1");                          // first read after reset wins
    step(3'b010, 3'b000, '0, "R3");                          // owner re-read returns 0
    step(3'b001, 3'b000, '0, "R3");
    step(3'b000, 3'b001, wdat(0, 32'd1), "R6");              // non-owner release ignored
    step(3'b100, 3'b000, '0, "R6");
    step(3'b000, 3'b010, wdat(1, 32'h2), "R7");              // bit 0 clear ignored
    step(3'b001, 3'b000, '0, "R7");
    step(3'b000, 3'b010, wdat(1, 32'd1), "R5");              // valid release
    step(3'b100, 3'b000, '0, "R5");                          // agent 2 acquires
    step(3'b000, 3'b100, wdat(2, 32'hFFFF_FFFF), "R5");
    step(3'b111, 3'b000, '0, "R4");                          // agent 0 wins all-read
    step(3'b000, 3'b001, wdat(0, 32'd1), "R5");
    step(3'b110, 3'b000, '0, "R4");                          // agent 1 wins
    step(3'b000, 3'b010, wdat(1, 32'd3), "R5");
    step(3'b000, 3'b111, {3{32'd1}}, "R9");                  // writes while free
    step(3'b100, 3'b000, '0, "R9");
    step(3'b001, 3'b100, wdat(2, 32'd1), "R3");              // read during release cycle
    step(3'b001, 3'b000, '0, "R2");

    for (int k = 0; k < 400; k++) begin
      logic [N*DW-1:0] wd;
      wd = '0;
      for (int i = 0; i < N; i++) wd[i*DW +: DW] = DW'($urandom);
      step(N'($urandom), N'($urandom), wd, "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule